// File: doc/BRIEF.md
# Glitch-free two-clock multiplexer

This block picks one of two unrelated clocks and drives it onto a single output clock. Changing the selection never produces a runt pulse: the output only ever carries complete high phases of a source clock, and each low phase is at least as long as a source low phase. Each source has its own gating path. That path holds an enable flop clocked on the falling edge of its own clock, and an AND gate lets the clock through only while the enable is set. The gated clocks are ORed into the output.

The two paths are cross-coupled. A path may arm only while the other path's enable is clear, so during a handoff the old clock is shut off first. The output then rests low until the new clock is let through. The parameter SYNC_STAGES inserts rising-edge flops ahead of each falling-edge enable flop. With one stage, the feedback arriving from the other domain passes a two-stage synchronizer. Each handoff then takes one extra source cycle on each side. The block has no data interface, so there is no valid/ready handshake and no back-pressure. The select input is a plain level.

Top module: `glitch_free_clk_mux`

## Requirements
- R1: Select encoding is 0 for clk_a and 1 for clk_b. Once a selection has settled, clk_out rises and falls with the selected clock and has the same period.
- R2: Every high phase of clk_out is one complete high phase of one source clock, neither merged nor shortened. The two path enables are never set at the same time.
- R3: Each path enable changes only while its own clock is low. Every low phase of clk_out lasts at least as long as the shorter source low phase.
- R4: While rst_n is low, both enables are clear and clk_out stays low.
- R5: With SYNC_STAGES = 0, the first clk_out rise after reset release is the first rising edge of the selected clock that follows that clock's first falling edge after the release.
- R6: When select changes, the old path's enable drops at a falling edge of the old clock. That edge is the first falling edge after the change when SYNC_STAGES = 0, and the first falling edge after one rising edge when SYNC_STAGES = 1. clk_out falls with that edge and then stays low. The new enable is set at a falling edge of the new clock, found the same way but counted from the moment the old enable drops. clk_out rises again at the next rising edge of the new clock.
- R7: With SYNC_STAGES = 1, start-up waits for one rising edge of the selected clock before the falling-edge capture. The first clk_out rise is therefore the first rising edge after the falling edge that follows the first rising edge after reset release.
- R8: With SYNC_STAGES = 0, R2 and R3 hold for any timing of select, including changes faster than either clock. With SYNC_STAGES = 1, select must stay stable for at least four cycles of the slower clock between changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Source clock chosen when sel is 0 |
| clk_b | input | 1 | Source clock chosen when sel is 1 |
| rst_n | input | 1 | Asynchronous active-low reset of both enable paths |
| sel | input | 1 | Clock choice: 0 selects clk_a, 1 selects clk_b |
| clk_out | output | 1 | Multiplexed clock |

## Verification
The hardest situation to reach from the ports is a handoff caught half-way. This is a select change that arrives while one path has already dropped and the other has not yet armed, so the cross-coupling must both abort and restart without letting a partial pulse out. The bench reaches it with a burst of select toggles far shorter than either clock period, applied only to an instance without the synchronizer stage. Meanwhile a pulse watcher measures every output phase against the two source phase lengths. The clock phases are placed so that edges of the two sources never coincide. This makes the exact handoff edges computable in the bench from the edge grids alone.

// File: rtl/gfcm_pkg.sv
package gfcm_pkg;
  localparam int NUM_SRC = 2;
  localparam int SRC_A   = 0;
  localparam int SRC_B   = 1;

  function automatic int peer_of(input int idx);
    return (idx + 1) % NUM_SRC;
  endfunction
endpackage

// File: rtl/gfcm_sync_stage.sv
module gfcm_sync_stage #(
  parameter int STAGES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_chain
      logic [STAGES-1:0] sr;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sr <= '0;
        end else begin
          sr[0] <= d;
          for (int k = 1; k < STAGES; k++) begin
            sr[k] <= sr[k-1];
          end
        end
      end
      assign q = sr[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/gfcm_path.sv
module gfcm_path #(
  parameter int SYNC_STAGES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic want,
  input  logic peer_en,
  output logic en,
  output logic gclk
);
  logic arm_d;
  logic arm_q;

  // arm only when the other path has shut off
  assign arm_d = want & ~peer_en;

  gfcm_sync_stage #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (arm_d),
    .q     (arm_q)
  );

  // falling-edge capture: enable moves only while clk is low
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) en <= 1'b0;
    else        en <= arm_q;
  end

  assign gclk = clk & en;
endmodule

// File: rtl/gfcm_merge.sv
module gfcm_merge #(
  parameter int N = 2
) (
  input  logic [N-1:0] gclk,
  output logic         clk_out
);
  assign clk_out = |gclk;
endmodule

// File: rtl/glitch_free_clk_mux.sv
module glitch_free_clk_mux
  import gfcm_pkg::*;
#(
  parameter int SYNC_STAGES = 1
) (
  input  logic clk_a,
  input  logic clk_b,
  input  logic rst_n,
  input  logic sel,
  output logic clk_out
);
  logic [NUM_SRC-1:0] src_clk;
  logic [NUM_SRC-1:0] want;
  logic [NUM_SRC-1:0] en;
  logic [NUM_SRC-1:0] gclk;

  assign src_clk[SRC_A] = clk_a;
  assign src_clk[SRC_B] = clk_b;
  assign want[SRC_A]    = ~sel;
  assign want[SRC_B]    = sel;

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_path
      gfcm_path #(.SYNC_STAGES(SYNC_STAGES)) u_path (
        .clk     (src_clk[i]),
        .rst_n   (rst_n),
        .want    (want[i]),
        .peer_en (en[peer_of(i)]),
        .en      (en[i]),
        .gclk    (gclk[i])
      );
    end
  endgenerate

  gfcm_merge #(.N(NUM_SRC)) u_merge (
    .gclk    (gclk),
    .clk_out (clk_out)
  );
endmodule

// File: rtl/glitch_free_clk_mux_checker.sv
module glitch_free_clk_mux_checker (
  input logic clk_a,
  input logic clk_b,
  input logic rst_n,
  input logic clk_out,
  input logic en_a,
  input logic en_b
);
  always @(en_a or en_b) begin
    if (rst_n) begin
      a_r2_one_path: assert (!(en_a && en_b))
        else $error("both clock paths enabled");
    end
  end

  always @(en_a) begin
    if (rst_n) begin
      a_r3_a_moves_low: assert (!clk_a)
        else $error("path A enable moved while clk_a high");
    end
  end

  always @(en_b) begin
    if (rst_n) begin
      a_r3_b_moves_low: assert (!clk_b)
        else $error("path B enable moved while clk_b high");
    end
  end

  a_r1_rise_needs_path: assert property (
    @(posedge clk_out) disable iff (!rst_n) (en_a || en_b)
  ) else $error("output rose with no path enabled");

  a_r6_a_after_b_off: assert property (
    @(posedge clk_a) disable iff (!rst_n) $rose(en_a) |-> !en_b
  ) else $error("path A armed while path B on");

  a_r6_b_after_a_off: assert property (
    @(posedge clk_b) disable iff (!rst_n) $rose(en_b) |-> !en_a
  ) else $error("path B armed while path A on");
endmodule

bind glitch_free_clk_mux glitch_free_clk_mux_checker u_chk (
  .clk_a   (clk_a),
  .clk_b   (clk_b),
  .rst_n   (rst_n),
  .clk_out (clk_out),
  .en_a    (en[0]),
  .en_b    (en[1])
);

// File: tb/test_glitch_free_clk_mux.sv
`timescale 1ps/1ps
module clk_pulse_watch #(
  parameter longint MIN_LOW = 5000,
  parameter longint HIGH_A  = 5000,
  parameter longint HIGH_B  = 6200,
  parameter string  TAG     = "x"
) (
  input  logic   clk_out,
  input  logic   rst_n,
  output longint last_rise,
  output longint gap_start,
  output longint period,
  output int     checks,
  output int     errs
);
  longint lr = -1, lf = -1, gs = -1, per = -1;
  int nc = 0, ne = 0;
  bit prev = 1'b0;

  assign last_rise = lr;
  assign gap_start = gs;
  assign period    = per;
  assign checks    = nc;
  assign errs      = ne;

  always @(clk_out or rst_n) begin
    longint now;
    now = $time;
    if (!rst_n) begin
      lr = -1; lf = -1; gs = -1; per = -1; prev = clk_out;
    end else if (clk_out && !prev) begin
      if (lf >= 0) begin
        nc++;
        if (now - lf < MIN_LOW) begin
          ne++;
          $display("FAIL R3 %s low phase actual %0d expected >= %0d", TAG, now - lf, MIN_LOW);
        end
      end
      per = (lr >= 0) ? now - lr : -1;
      gs = lf;
      lr = now;
      prev = 1'b1;
    end else if (!clk_out && prev) begin
      if (lr >= 0) begin
        nc++;
        if (now - lr != HIGH_A && now - lr != HIGH_B) begin
          ne++;
          $display("FAIL R2 %s high phase actual %0d expected %0d or %0d", TAG, now - lr, HIGH_A, HIGH_B);
        end
      end
      lf = now;
      prev = 1'b0;
    end
  end
endmodule

module test_glitch_free_clk_mux;
  localparam longint CLK_PERIOD = 10000;
  localparam longint A_HALF     = CLK_PERIOD / 2;
  localparam longint B_HALF     = 6200;
  localparam longint B_PERIOD   = 2 * B_HALF;
  localparam longint B_OFFSET   = 1100;
  localparam longint WATCHDOG   = 200 * 1000 * CLK_PERIOD / 10;

  logic clk_a = 1'b0;
  logic clk_b = 1'b0;
  logic rst_n = 1'b0;
  logic sel_s0 = 1'b0;
  logic sel_s1 = 1'b0;
  logic out_s0, out_s1;

  int n_checks = 0;
  int n_errs = 0;
  bit done = 1'b0;

  longint lr0, gs0, per0, lr1, gs1, per1;
  int c0, e0, c1, e1;

  glitch_free_clk_mux #(.SYNC_STAGES(0)) i_glitch_free_clk_mux_basic (
    .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n), .sel(sel_s0), .clk_out(out_s0));
  glitch_free_clk_mux i_glitch_free_clk_mux (
    .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n), .sel(sel_s1), .clk_out(out_s1));

  clk_pulse_watch #(.MIN_LOW(A_HALF), .HIGH_A(A_HALF), .HIGH_B(B_HALF), .TAG("basic")) u_w0 (
    .clk_out(out_s0), .rst_n(rst_n), .last_rise(lr0), .gap_start(gs0), .period(per0),
    .checks(c0), .errs(e0));
  clk_pulse_watch #(.MIN_LOW(A_HALF), .HIGH_A(A_HALF), .HIGH_B(B_HALF), .TAG("sync")) u_w1 (
    .clk_out(out_s1), .rst_n(rst_n), .last_rise(lr1), .gap_start(gs1), .period(per1),
    .checks(c1), .errs(e1));

  initial forever #(A_HALF) clk_a = ~clk_a;
  initial begin
    #(B_OFFSET);
    forever begin
      clk_b = 1'b1; #(B_HALF);
      clk_b = 1'b0; #(B_HALF);
    end
  end

  // first grid edge strictly after t
  function automatic longint nx(input longint t, input longint off, input longint per);
    if (t < off) return off;
    return off + ((t - off) / per + 1) * per;
  endfunction

  // falling edge at which a path's enable captures, counted from t
  function automatic longint cap_time(input longint t, input int stages, input bit is_b);
    longint x;
    x = t;
    for (int k = 0; k < stages; k++)
      x = is_b ? nx(x, B_OFFSET, B_PERIOD) : nx(x, A_HALF, CLK_PERIOD);
    return is_b ? nx(x, B_OFFSET + B_HALF, B_PERIOD) : nx(x, CLK_PERIOD, CLK_PERIOD);
  endfunction

  function automatic longint rise_after(input longint t, input bit is_b);
    return is_b ? nx(t, B_OFFSET, B_PERIOD) : nx(t, A_HALF, CLK_PERIOD);
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_errs++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_until(input longint t);
    if (t > $time) #(t - $time);
  endtask

  task automatic report;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_checks + c0 + c1, n_errs + e0 + e1);
      $finish;
    end
  endtask

  // handoff check for one instance (R6)
  task automatic switch_check(input longint t, input bit to_b);
    longint d0, r0, d1, r1;
    d0 = cap_time(t, 0, !to_b);
    r0 = rise_after(cap_time(d0, 0, to_b), to_b);
    d1 = cap_time(t, 1, !to_b);
    r1 = rise_after(cap_time(d1, 1, to_b), to_b);
    wait_until(r0 + 100);
    chk("R6 basic new clock first rise", lr0, r0);
    chk("R6 basic output low from old drop", gs0, d0);
    wait_until(r1 + 100);
    chk("R6 sync new clock first rise", lr1, r1);
    chk("R6 sync output low from old drop", gs1, d1);
  endtask

  initial begin
    #(WATCHDOG);
    n_errs++;
    $display("FAIL watchdog expired actual %0d expected done", $time);
    report();
  end

  initial begin
    longint t_rel, t;
    void'($urandom(32'd1357));

    // R4: reset holds output low
    for (int k = 1; k <= 4; k++) begin
      wait_until(k * 20050);
      chk("R4 basic clk_out in reset", longint'(out_s0), 0);
      chk("R4 sync clk_out in reset", longint'(out_s1), 0);
    end

    t_rel = 208050;
    wait_until(t_rel);
    rst_n = 1'b1;
    t = rise_after(cap_time(t_rel, 0, 1'b0), 1'b0);
    wait_until(t + 100);
    chk("R5 basic first rise after reset", lr0, t);
    chk("R7 sync not yet started", lr1, -1);
    t = rise_after(cap_time(t_rel, 1, 1'b0), 1'b0);
    wait_until(t + 100);
    chk("R7 sync first rise after reset", lr1, t);

    // R1 steady clock A
    wait_until(300050);
    chk("R1 basic period on A", per0, CLK_PERIOD);
    chk("R1 sync period on A", per1, CLK_PERIOD);

    t = 400050;
    wait_until(t);
    sel_s0 = 1'b1; sel_s1 = 1'b1;
    switch_check(t, 1'b1);
    wait_until(t + 200000);
    chk("R1 basic period on B", per0, B_PERIOD);
    chk("R1 sync period on B", per1, B_PERIOD);

    t = 700050;
    wait_until(t);
    sel_s0 = 1'b0; sel_s1 = 1'b0;
    switch_check(t, 1'b0);
    wait_until(t + 200000);
    chk("R1 basic period back on A", per0, CLK_PERIOD);
    chk("R1 sync period back on A", per1, CLK_PERIOD);

    // random select changes held long enough for both forms (R8)
    for (int k = 0; k < 30; k++) begin
      #(100000 + 100 * ($urandom % 500));
      sel_s0 = ~sel_s0;
      sel_s1 = sel_s0;
    end
    sel_s0 = 1'b1; sel_s1 = 1'b1;
    #(200000);
    chk("R1 basic period after random run", per0, B_PERIOD);
    chk("R1 sync period after random run", per1, B_PERIOD);

    // R8: fast select burst on the basic form only
    for (int k = 0; k < 60; k++) begin
      #(300 + 100 * ($urandom % 90));
      sel_s0 = ~sel_s0;
    end
    sel_s0 = 1'b0;
    #(200000);
    chk("R8 basic period after fast burst", per0, CLK_PERIOD);
    chk("R8 sync unaffected by other burst", per1, B_PERIOD);

    report();
  end
endmodule